// File: doc/BRIEF.md
# SPI Serial EEPROM Target Model

This block is an SPI target (mode 0, MSB first) that answers like a small serial EEPROM whose storage is an on-chip byte array. A frame starts when the chip select goes low. The first byte is a command. Depending on the command, the block then takes one to three address bytes and either streams stored bytes back on the data-out pin or collects bytes to be written. Another command returns a status byte. The SPI pins are sampled in the system clock domain, so the serial clock must run well below the system clock.

Write data goes into a one-page buffer first. The buffer is copied into the array only when chip select rises after a whole number of data bytes. A busy window then opens, lasting a set number of clock cycles. During that window the block ignores every command except the status read. A write is accepted only after a latch-set command, and the latch clears by itself when the busy window ends. The number of address bytes is a parameter; in the 9-bit mode, address bit 8 travels inside the command byte. Write data that passes the end of the page wraps to the start of the same page.

Top module: `spi_eeprom_model`

## Requirements
- R1: After reset the status byte reads 0x00, and the data-out pin is 0 while chip select is high. Status bits 7..2 always read 0.
- R2: The status byte has the write-in-progress flag at bit 0 and the write-enable latch at bit 1. Command 0x06 sets the latch and command 0x04 clears it.
- R3: A write command (0x02) that arrives while the latch is clear is ignored: it raises no busy window and changes no stored byte. Every commit happens with the latch set.
- R4: A read command (0x03) followed by the address streams stored bytes, MSB first, starting at that address. The stream continues for as long as chip select stays low, and it wraps from the last location to location 0.
- R5: Parameter ADDR_MODE gives 1, 2 or 3 address bytes, sent MSB first. The value 9 selects 9-bit mode: one address byte, with address bit 8 taken from bit 3 of the command byte (0x0B reads and 0x0A writes the upper half). Address bits beyond the array size are dropped.
- R6: Successive write data bytes go to successive offsets within one page. After the last offset of the page, writing continues at offset 0 of the same page, and a later byte replaces an earlier one. No other page changes.
- R7: A write is committed only when chip select rises after at least one whole data byte, with no partial byte pending. A frame with a partial byte or with no data writes nothing, raises no busy window and leaves the latch set.
- R8: After a commit, status bit 0 is 1 for exactly BUSY_CYCLES clock cycles while the latch still reads 1. When the window ends, both bits read 0.
- R9: While status bit 0 is 1, every command except the status read (0x05) is ignored: a read drives 0 and a write stores nothing.
- R10: After command 0x05, every following byte of the same frame returns the status as it stands at the start of that byte, so polling inside one frame sees the end of the busy window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all SPI pins are oversampled on it |
| rstN | input | 1 | Active-low synchronous reset |
| sck | input | 1 | SPI serial clock, idle low, data sampled on its rising edge |
| csN | input | 1 | Active-low chip select; its rising edge ends a frame |
| mosi | input | 1 | Serial data from the controller |
| miso | output | 1 | Serial data to the controller |

## Verification
The hardest behaviour to reach from the pins is how the block handles frames that arrive during the busy window. The bench commits a page and raises chip select, then sends a write frame and a read frame at once, both well inside the window. After that it polls status in a single continuous frame and checks when bit 0 drops against the expected window. A second hard case is a frame cut off in the middle of a byte, which should leave everything unchanged except that the latch stays set. The bench reaches it by sending only three bits of the last byte before raising chip select. Behind both of these, the bench fills the whole array page by page through the 9-bit command form and reads it back in one stream that wraps past the end.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam logic [7:0] OP_MEM_WR    = 8'h02;
  localparam logic [7:0] OP_MEM_RD    = 8'h03;
  localparam logic [7:0] OP_LATCH_OFF = 8'h04;
  localparam logic [7:0] OP_STAT_RD   = 8'h05;
  localparam logic [7:0] OP_LATCH_ON  = 8'h06;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic bufStart;
    logic bufWrite;
    logic commit;
  } ee_strobe_t;

  typedef enum logic [2:0] {
    ST_OPCODE, ST_ADDR, ST_LOAD, ST_READ, ST_WRITE, ST_STATUS, ST_IGNORE
  } ee_state_t;
endpackage

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
  import spi_ee_pkg::*;
#(
  parameter int AW        = 9,
  parameter int PW        = 4,
  parameter int ADDR_MODE = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sck,
  input  logic          csN,
  input  logic          mosi,
  output logic          miso,
  output ee_strobe_t    stb,
  output logic [AW-1:0] curAddr,
  output logic [PW-1:0] wrOff,
  output logic [7:0]    wrData,
  input  logic [7:0]    statusByte,
  input  logic [7:0]    memRdData
);
  localparam bit NINE_BIT   = (ADDR_MODE == 9);
  localparam int ADDR_BYTES = NINE_BIT ? 1 : ADDR_MODE;

  // two-flop synchronisers plus one stage for edge detection
  logic [2:0] sckSync, csSync;
  logic [1:0] mosiSync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckSync  <= '0;
      csSync   <= '1;
      mosiSync <= '0;
    end else begin
      sckSync  <= {sckSync[1:0], sck};
      csSync   <= {csSync[1:0], csN};
      mosiSync <= {mosiSync[0], mosi};
    end
  end

  logic sckRise, csHigh, csRise, bitIn;
  assign sckRise = sckSync[1] & ~sckSync[2];
  assign csHigh  = csSync[1];
  assign csRise  = csSync[1] & ~csSync[2];
  assign bitIn   = mosiSync[1];

  ee_state_t      state;
  logic [2:0]     bitCnt;
  logic [6:0]     shiftIn;
  logic [7:0]     txShift;
  logic [AW-1:0]  addrAcc;
  logic [AW-1:0]  addrReg;
  logic [1:0]     addrLeft;
  logic           isWrite;
  logic           gotData;

  logic [7:0]    rxByte, cmd;
  logic          byteDone, busyNow, latchNow;
  logic [AW-1:0] addrNext, pageInc;

  assign rxByte   = {shiftIn, bitIn};
  assign byteDone = sckRise && !csHigh && (bitCnt == 3'd7);
  assign cmd      = NINE_BIT ? (rxByte & 8'hF7) : rxByte;
  assign busyNow  = statusByte[0];
  assign latchNow = statusByte[1];
  assign addrNext = AW'({addrAcc, rxByte});
  assign pageInc  = {addrReg[AW-1:PW], addrReg[PW-1:0] + 1'b1};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_OPCODE;
      bitCnt   <= '0;
      shiftIn  <= '0;
      txShift  <= '0;
      addrAcc  <= '0;
      addrReg  <= '0;
      addrLeft <= '0;
      isWrite  <= 1'b0;
      gotData  <= 1'b0;
      stb      <= '0;
      wrOff    <= '0;
      wrData   <= '0;
    end else begin
      stb <= '0;
      if (csHigh) begin
        if (csRise && state == ST_WRITE && bitCnt == 3'd0 && gotData)
          stb.commit <= 1'b1;
        state   <= ST_OPCODE;
        bitCnt  <= '0;
        gotData <= 1'b0;
        txShift <= '0;
      end else begin
        if (sckRise) begin
          bitCnt  <= bitCnt + 1'b1;
          shiftIn <= {shiftIn[5:0], bitIn};
          if (state == ST_READ || state == ST_STATUS)
            txShift <= {txShift[6:0], 1'b0};
        end
        if (state == ST_LOAD) begin
          if (isWrite) begin
            stb.bufStart <= 1'b1;
            state        <= ST_WRITE;
          end else begin
            txShift <= memRdData;
            addrReg <= addrReg + 1'b1;
            state   <= ST_READ;
          end
        end
        if (byteDone) begin
          case (state)
            ST_OPCODE: begin
              addrAcc  <= AW'(NINE_BIT ? rxByte[3] : 1'b0);
              addrLeft <= 2'(ADDR_BYTES);
              if (busyNow && cmd != OP_STAT_RD) begin
                state <= ST_IGNORE;
              end else begin
                case (cmd)
                  OP_STAT_RD: begin
                    txShift <= statusByte;
                    state   <= ST_STATUS;
                  end
                  OP_LATCH_ON: begin
                    stb.setWel <= 1'b1;
                    state      <= ST_IGNORE;
                  end
                  OP_LATCH_OFF: begin
                    stb.clrWel <= 1'b1;
                    state      <= ST_IGNORE;
                  end
                  OP_MEM_RD: begin
                    isWrite <= 1'b0;
                    state   <= ST_ADDR;
                  end
                  OP_MEM_WR: begin
                    isWrite <= 1'b1;
                    state   <= latchNow ? ST_ADDR : ST_IGNORE;
                  end
                  default: state <= ST_IGNORE;
                endcase
              end
            end
            ST_ADDR: begin
              addrAcc  <= addrNext;
              addrLeft <= addrLeft - 1'b1;
              if (addrLeft == 2'd1) begin
                addrReg <= addrNext;
                state   <= ST_LOAD;
              end
            end
            ST_READ: begin
              txShift <= memRdData;
              addrReg <= addrReg + 1'b1;
            end
            ST_STATUS: txShift <= statusByte;
            ST_WRITE: begin
              stb.bufWrite <= 1'b1;
              wrOff        <= addrReg[PW-1:0];
              wrData       <= rxByte;
              addrReg      <= pageInc;
              gotData      <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign curAddr = addrReg;
  assign miso    = (state == ST_READ || state == ST_STATUS) ? txShift[7] : 1'b0;
endmodule

// File: rtl/spi_ee_datapath.sv
module spi_ee_datapath
  import spi_ee_pkg::*;
#(
  parameter int MEM_BYTES   = 512,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 800,
  parameter int AW          = 9,
  parameter int PW          = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  ee_strobe_t    stb,
  input  logic [AW-1:0] curAddr,
  input  logic [PW-1:0] wrOff,
  input  logic [7:0]    wrData,
  output logic [7:0]    statusByte,
  output logic [7:0]    memRdData
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [7:0]         memArr  [MEM_BYTES];
  logic [7:0]         pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageMask;
  logic [AW-PW-1:0]   pageBase;
  logic               welReg;
  logic [CW-1:0]      busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      welReg   <= 1'b0;
      busyCnt  <= '0;
      pageMask <= '0;
      pageBase <= '0;
    end else begin
      if (stb.commit) begin
        busyCnt <= CW'(BUSY_CYCLES);
      end else if (busyCnt != '0) begin
        busyCnt <= busyCnt - 1'b1;
        if (busyCnt == CW'(1)) welReg <= 1'b0;
      end
      if (stb.setWel) welReg <= 1'b1;
      if (stb.clrWel) welReg <= 1'b0;
      if (stb.bufStart) begin
        pageMask <= '0;
        pageBase <= curAddr[AW-1:PW];
      end
      if (stb.bufWrite) pageMask[wrOff] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.bufWrite) pageBuf[wrOff] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (stb.commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (pageMask[i]) memArr[{pageBase, PW'(i)}] <= pageBuf[i];
      end
    end
  end

  assign memRdData  = memArr[curAddr];
  assign statusByte = {6'b0, welReg, busyCnt != '0};
endmodule

// File: rtl/spi_eeprom_model.sv
module spi_eeprom_model
  import spi_ee_pkg::*;
#(
  parameter int MEM_BYTES   = 512,
  parameter int PAGE_BYTES  = 16,
  parameter int ADDR_MODE   = 9,
  parameter int BUSY_CYCLES = 800
) (
  input  logic clk,
  input  logic rstN,
  input  logic sck,
  input  logic csN,
  input  logic mosi,
  output logic miso
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);

  ee_strobe_t    stb;
  logic [AW-1:0] curAddr;
  logic [PW-1:0] wrOff;
  logic [7:0]    wrData;
  logic [7:0]    statusByte;
  logic [7:0]    memRdData;
  logic          commitPulse;

  assign commitPulse = stb.commit;

  spi_ee_ctrl #(.AW(AW), .PW(PW), .ADDR_MODE(ADDR_MODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .mosi(mosi), .miso(miso),
    .stb(stb), .curAddr(curAddr), .wrOff(wrOff), .wrData(wrData),
    .statusByte(statusByte), .memRdData(memRdData)
  );

  spi_ee_datapath #(
    .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES),
    .AW(AW), .PW(PW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .curAddr(curAddr), .wrOff(wrOff),
    .wrData(wrData), .statusByte(statusByte), .memRdData(memRdData)
  );
endmodule

// File: rtl/spi_ee_checker.sv
module spi_ee_checker #(
  parameter int BUSY_CYCLES = 800
) (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic [1:0] statusLow,
  input logic       commitPulse
);
  logic [31:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN) runLen <= '0;
    else if (statusLow[0]) runLen <= runLen + 1;
    else runLen <= '0;
  end

  // R8: busy flag follows a commit
  a_r8_busy_set: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |=> statusLow[0]);

  // R8: busy window has the exact length
  a_r8_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    (!statusLow[0] && runLen != 0) |-> (runLen == BUSY_CYCLES));

  // R8: latch is clear once the window ends
  a_r8_latch_clear: assert property (@(posedge clk) disable iff (!rstN)
    (!statusLow[0] && runLen != 0) |-> !statusLow[1]);

  // R3: a commit needs the latch
  a_r3_commit_latch: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> statusLow[1]);

  // R9: no commit starts inside a busy window
  a_r9_commit_idle: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> !statusLow[0]);

  // R7: commit only once chip select is high
  a_r7_commit_cs_high: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> csN);
endmodule

bind spi_eeprom_model spi_ee_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .statusLow(statusByte[1:0]),
  .commitPulse(commitPulse)
);

// File: tb/tb_spi_eeprom_model.sv
module tb_spi_eeprom_model;
  localparam int MEM  = 512;
  localparam int PAGE = 16;
  localparam int BUSY = 800;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sck = 1'b0;
  logic csN = 1'b1;
  logic mosi = 1'b0;
  logic miso;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  bit finished = 1'b0;
  logic [7:0] model [MEM];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_eeprom_model #(.MEM_BYTES(MEM), .PAGE_BYTES(PAGE), .ADDR_MODE(9),
                     .BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .mosi(mosi), .miso(miso)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  function automatic logic [7:0] opFor(logic [7:0] base, int a);
    return base | (8'((a >> 8) & 1) << 3);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic sendBits(input logic [7:0] tx, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic frameStart;
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frameEnd;
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] r;
    frameStart; xfer(op, r); frameEnd;
  endtask

  task automatic rdStatus(output logic [7:0] s);
    logic [7:0] r;
    frameStart; xfer(8'h05, r); xfer(8'hFF, s); frameEnd;
  endtask

  task automatic readCheck(input string tag, input int addr, input int n);
    logic [7:0] r;
    frameStart;
    xfer(opFor(8'h03, addr), r);
    xfer(8'(addr), r);
    for (int i = 0; i < n; i++) begin
      xfer(8'hFF, r);
      chk(tag, r, model[(addr + i) % MEM]);
    end
    frameEnd;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, r, prev;
    int base, t0, t1, polls;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    chk("R1 idle miso", miso, 1'b0);
    rdStatus(s); chk("R1 status after reset", s, 8'h00);

    cmd(8'h06); rdStatus(s); chk("R2 latch set", s, 8'h02);
    cmd(8'h04); rdStatus(s); chk("R2 latch cleared", s, 8'h00);

    // fill the whole array page by page (R5 upper half via 0x0A)
    for (int p = 0; p < MEM / PAGE; p++) begin
      base = p * PAGE;
      cmd(8'h06);
      frameStart;
      xfer(opFor(8'h02, base), r);
      xfer(8'(base), r);
      for (int k = 0; k < PAGE; k++) begin
        model[base + k] = pat(base + k);
        xfer(pat(base + k), r);
      end
      frameEnd;
      if (p == 0) begin
        rdStatus(s); chk("R8 busy with latch held", s, 8'h03);
      end
      repeat (BUSY + 20) @(negedge clk);
      if (p == 0) begin
        rdStatus(s); chk("R8 both bits clear after window", s, 8'h00);
      end
    end

    // R4: one stream over the whole array plus wrap
    frameStart;
    xfer(8'h03, r); xfer(8'h00, r);
    for (int a = 0; a < MEM + 2; a++) begin
      xfer(8'hFF, r);
      chk("R4 continuous stream", r, model[a % MEM]);
    end
    frameEnd;
    readCheck("R4 wrap at end of array", 12'h1FE, 4);

    // R5: 9-bit addressing
    readCheck("R5 upper half via opcode bit 3", 12'h1F0, 4);
    readCheck("R5 lower half", 12'h0F0, 4);

    // R3: write without latch
    frameStart;
    xfer(8'h02, r); xfer(8'h40, r);
    for (int k = 0; k < 3; k++) xfer(8'h55, r);
    frameEnd;
    repeat (20) @(negedge clk);
    rdStatus(s); chk("R3 no busy window", s, 8'h00);
    readCheck("R3 memory unchanged", 12'h040, 3);

    // R6: wrap inside the page at 0x100, start offset 12, 20 bytes
    cmd(8'h06);
    frameStart;
    xfer(8'h0A, r); xfer(8'h0C, r);
    for (int k = 0; k < 20; k++) begin
      model[12'h100 + ((12 + k) % PAGE)] = 8'(8'hC0 + k);
      xfer(8'(8'hC0 + k), r);
    end
    frameEnd;
    repeat (BUSY + 20) @(negedge clk);
    readCheck("R6 page wrap and neighbours", 12'h0F8, 32);

    // R7: partial byte and empty data
    cmd(8'h06);
    frameStart;
    xfer(8'h02, r); xfer(8'h20, r); xfer(8'h99, r);
    sendBits(8'hA0, 3);
    frameEnd;
    repeat (20) @(negedge clk);
    rdStatus(s); chk("R7 partial byte gives no window", s, 8'h02);
    readCheck("R7 partial byte writes nothing", 12'h020, 1);
    frameStart;
    xfer(8'h02, r); xfer(8'h21, r);
    frameEnd;
    rdStatus(s); chk("R7 no data gives no window", s, 8'h02);
    cmd(8'h04); rdStatus(s); chk("R2 latch cleared again", s, 8'h00);

    // R9 / R10: commands during the busy window, polling in one frame
    cmd(8'h06);
    frameStart;
    xfer(8'h02, r); xfer(8'h30, r);
    for (int k = 0; k < PAGE; k++) begin
      model[12'h030 + k] = 8'(8'hE0 + k);
      xfer(8'(8'hE0 + k), r);
    end
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    t0 = cyc;
    repeat (2 * HALF) @(negedge clk);

    frameStart;
    xfer(8'h02, r); xfer(8'h50, r); xfer(8'h77, r);
    frameEnd;
    frameStart;
    xfer(8'h03, r); xfer(8'h30, r);
    xfer(8'hFF, r); chk("R9 read blocked while busy", r, 8'h00);
    xfer(8'hFF, r); chk("R9 read blocked while busy", r, 8'h00);
    frameEnd;

    frameStart;
    xfer(8'h05, r);
    xfer(8'hFF, s);
    chk("R8 latch held during window", s, 8'h03);
    prev = s;
    polls = 0;
    while (s != 8'h00 && polls < 40) begin
      prev = s;
      xfer(8'hFF, s);
      polls++;
    end
    t1 = cyc;
    frameEnd;
    chk("R10 poll sees window end", s, 8'h00);
    chk("R10 last busy status", prev, 8'h03);
    chk("R10 window length seen by polling",
        ((t1 - t0) >= BUSY) && ((t1 - t0) <= BUSY + 200), 1'b1);
    readCheck("R9 write during window ignored", 12'h050, 1);
    readCheck("R9 committed page content", 12'h030, PAGE);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule